// File: doc/BRIEF.md
# Registered synchronous dual-port RAM

This block is a two-port static memory of 4096 words of 9 bits. The left and right ports are fully independent. Each port has its own clock, a hold (stall) input, an active-low select, a read/write-not line, a 12-bit address, 9-bit write data and an active-low asynchronous output enable. Each port returns 9-bit read data together with a drive flag. The drive flag stands in for a tri-state pad: while it is low the data lines read as zero. All 9 bits are plain data. No parity is generated or checked.

The select, direction, address and write data of a port are captured in an input register on that port's rising edge, unless the hold input is high. The operation in that register acts on the next edge of the same port. A write lands in the array at that edge. A read loads the port's output register at that edge. So a read presented before edge k is on the pins after edge k+1, and a write presented before edge k can be read back by an access captured at edge k+1. Both ports use the array at the same time without arbitration. The only conflict rule applies when both ports write the same word from the same edge: the right port's data is kept.

Top module: `dpram_sync2p`

## Requirements
- R1: The array holds 4096 words selected by a 12-bit address. Any 9-bit value written at any address, including address 4095 and the value 0x1FF, reads back unchanged from either port.
- R2: A read (select low, read/write-not high) captured at edge k puts the addressed word on the data output after edge k+1, with the drive flag high while output enable is low.
- R3: A write (select low, read/write-not low) captured at edge k lands in the array at edge k+1, and a read on the same port captured at edge k+1 returns the new word. A write never raises the drive flag of its own port.
- R4: While a port's hold input is high at an edge, its input register keeps select, direction, address and data. The port repeats its previous operation and ignores the new inputs.
- R5: A port whose captured select is high performs no write, and its drive flag is low after the next edge.
- R6: Output enable acts without a clock. While it is high the drive flag is low. Taking it low again restores the pending read word at once.
- R7: The data output reads zero whenever the drive flag is low.
- R8: A read on one port captured at least one edge after the other port captured a write to the same word returns the new data. A read captured on the same edge as that write returns the previous contents.
- R9: When both ports capture a write to the same word on the same edge, the right port's data is the word that remains.
- R10: After reset, both input registers hold the deselected state. No write occurs and neither drive flag is high until an operation has been captured and executed.
- R11: Random mixes of reads, writes, deselects, holds and output-enable changes on both ports at once match a word-level reference model on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset of both ports' registers |
| l_hold | input | 1 | Left: high keeps the input register unchanged |
| l_sel_n | input | 1 | Left: active-low select |
| l_rd_wn | input | 1 | Left: 1 = read, 0 = write |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 9 | Left write data |
| l_oe_n | input | 1 | Left: asynchronous active-low output enable |
| l_q | output | 9 | Left read data, zero when not driven |
| l_q_drv | output | 1 | Left: read data is being driven |
| r_hold | input | 1 | Right: high keeps the input register unchanged |
| r_sel_n | input | 1 | Right: active-low select |
| r_rd_wn | input | 1 | Right: 1 = read, 0 = write |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 9 | Right write data |
| r_oe_n | input | 1 | Right: asynchronous active-low output enable |
| r_q | output | 9 | Right read data, zero when not driven |
| r_q_drv | output | 1 | Right: read data is being driven |

## Verification
The hardest situation to reach from the ports is the interaction between the two ports on one word: a read captured on the same edge as the other port's write, the read captured one edge later, and two writes to the same word from the same edge. Directed sequences place these captures on exact edges and check both the old and the new value against literal expectations. The hold behaviour is reached by changing the inputs while the hold input is high and then reading back, so that a wrongly captured value would show up. A seeded random phase confines addresses to sixteen words so that collisions, held operations and output-enable toggles overlap often, and a reference model checks every cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Operation held in a port's input register.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  // Select and direction pins to operation.
  function automatic port_op_e decode_op(input logic sel_n, input logic rd_wn);
    if (sel_n)      return OP_IDLE;
    else if (rd_wn) return OP_READ;
    else            return OP_WRITE;
  endfunction

  // Word ownership: equal tags mean the left bank holds the latest data.
  function automatic logic left_owns(input logic tag_l, input logic tag_r);
    return (tag_l == tag_r);
  endfunction

  // Tag value a side stores on writing, given the other side's tag.
  function automatic logic tag_on_write(input logic is_right, input logic other_tag);
    return is_right ? ~other_tag : other_tag;
  endfunction

endpackage

// File: rtl/dpram_capture.sv
module dpram_capture
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel_n,
  input  logic              rd_wn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_op_e          op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  logic load;
  assign load = ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      op_q   <= decode_op(sel_n, rd_wn);
      addr_q <= addr;
      data_q <= wdata;
    end
  end

endmodule

// File: rtl/dpram_core.sv
module dpram_core
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              rst_n,
  input  port_op_e          l_op,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_data,
  input  port_op_e          r_op,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_data,
  output logic [DATA_W-1:0] l_rd_q,
  output logic              l_rvalid,
  output logic [DATA_W-1:0] r_rd_q,
  output logic              r_rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  // Each side writes only its own bank and tag vector; the tags tell
  // which bank holds the most recent copy of every word.
  logic [DATA_W-1:0] bank_l [DEPTH];
  logic [DATA_W-1:0] bank_r [DEPTH];
  logic [DEPTH-1:0]  tag_l;
  logic [DEPTH-1:0]  tag_r;

  logic l_we, r_we, l_yield, l_commit;
  logic [DATA_W-1:0] l_word, r_word;

  assign l_we     = (l_op == OP_WRITE);
  assign r_we     = (r_op == OP_WRITE);
  // Left steps aside when the right side commits to the same word.
  assign l_yield  = l_we && r_we && (l_addr == r_addr);
  assign l_commit = l_we && !l_yield;

  assign l_word = left_owns(tag_l[l_addr], tag_r[l_addr]) ? bank_l[l_addr] : bank_r[l_addr];
  assign r_word = left_owns(tag_l[r_addr], tag_r[r_addr]) ? bank_l[r_addr] : bank_r[r_addr];

  always_ff @(posedge clk_l) begin
    if (l_commit) begin
      bank_l[l_addr] <= l_data;
      tag_l[l_addr]  <= tag_on_write(1'b0, tag_r[l_addr]);
    end
  end

  always_ff @(posedge clk_r) begin
    if (r_we) begin
      bank_r[r_addr] <= r_data;
      tag_r[r_addr]  <= tag_on_write(1'b1, tag_l[r_addr]);
    end
  end

  always_ff @(posedge clk_l or negedge rst_n) begin
    if (!rst_n) begin
      l_rvalid <= 1'b0;
      l_rd_q   <= '0;
    end else if (l_op == OP_READ) begin
      l_rvalid <= 1'b1;
      l_rd_q   <= l_word;
    end else begin
      l_rvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n) begin
      r_rvalid <= 1'b0;
      r_rd_q   <= '0;
    end else if (r_op == OP_READ) begin
      r_rvalid <= 1'b1;
      r_rd_q   <= r_word;
    end else begin
      r_rvalid <= 1'b0;
    end
  end

endmodule

// File: rtl/dpram_outgate.sv
module dpram_outgate #(
  parameter int DATA_W = 9
) (
  input  logic              rvalid,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_q,
  output logic [DATA_W-1:0] q,
  output logic              q_drv
);

  assign q_drv = rvalid & ~oe_n;
  assign q     = q_drv ? rd_q : '0;

endmodule

// File: rtl/dpram_sync2p.sv
module dpram_sync2p
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk_l,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              l_hold,
  input  logic              l_sel_n,
  input  logic              l_rd_wn,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_oe_n,
  output logic [DATA_W-1:0] l_q,
  output logic              l_q_drv,
  input  logic              r_hold,
  input  logic              r_sel_n,
  input  logic              r_rd_wn,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_oe_n,
  output logic [DATA_W-1:0] r_q,
  output logic              r_q_drv
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]  clk_s, hold_s, seln_s, rdwn_s, oen_s, rvalid_s, drv_s;
  logic [ADDR_W-1:0] addr_s [NPORT];
  logic [ADDR_W-1:0] addr_q [NPORT];
  logic [DATA_W-1:0] wdat_s [NPORT];
  logic [DATA_W-1:0] data_q [NPORT];
  logic [DATA_W-1:0] rd_q   [NPORT];
  logic [DATA_W-1:0] q_s    [NPORT];
  port_op_e          op_q   [NPORT];

  assign clk_s  = {clk_r, clk_l};
  assign hold_s = {r_hold, l_hold};
  assign seln_s = {r_sel_n, l_sel_n};
  assign rdwn_s = {r_rd_wn, l_rd_wn};
  assign oen_s  = {r_oe_n, l_oe_n};
  assign addr_s[0] = l_addr;
  assign addr_s[1] = r_addr;
  assign wdat_s[0] = l_wdata;
  assign wdat_s[1] = r_wdata;

  for (genvar s = 0; s < NPORT; s++) begin : g_port
    dpram_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk    (clk_s[s]),
      .rst_n  (rst_n),
      .hold   (hold_s[s]),
      .sel_n  (seln_s[s]),
      .rd_wn  (rdwn_s[s]),
      .addr   (addr_s[s]),
      .wdata  (wdat_s[s]),
      .op_q   (op_q[s]),
      .addr_q (addr_q[s]),
      .data_q (data_q[s])
    );

    dpram_outgate #(.DATA_W(DATA_W)) u_gate (
      .rvalid (rvalid_s[s]),
      .oe_n   (oen_s[s]),
      .rd_q   (rd_q[s]),
      .q      (q_s[s]),
      .q_drv  (drv_s[s])
    );
  end

  dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_l    (clk_l),
    .clk_r    (clk_r),
    .rst_n    (rst_n),
    .l_op     (op_q[0]),
    .l_addr   (addr_q[0]),
    .l_data   (data_q[0]),
    .r_op     (op_q[1]),
    .r_addr   (addr_q[1]),
    .r_data   (data_q[1]),
    .l_rd_q   (rd_q[0]),
    .l_rvalid (rvalid_s[0]),
    .r_rd_q   (rd_q[1]),
    .r_rvalid (rvalid_s[1])
  );

  assign l_q     = q_s[0];
  assign l_q_drv = drv_s[0];
  assign r_q     = q_s[1];
  assign r_q_drv = drv_s[1];

endmodule

// File: rtl/dpram_sync2p_checker.sv
module dpram_sync2p_checker
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 9
) (
  input logic              clk_l,
  input logic              clk_r,
  input logic              rst_n,
  input logic              l_hold,
  input logic              l_oe_n,
  input logic              l_q_drv,
  input logic [DATA_W-1:0] l_q,
  input port_op_e          l_op,
  input logic [ADDR_W-1:0] l_addr_q,
  input logic              l_rvalid,
  input logic              r_hold,
  input logic              r_oe_n,
  input logic              r_q_drv,
  input logic [DATA_W-1:0] r_q,
  input port_op_e          r_op,
  input logic [ADDR_W-1:0] r_addr_q,
  input logic              r_rvalid
);

  AST_L_READ_VALID: assert property (@(posedge clk_l) disable iff (!rst_n) (l_op == OP_READ) |=> l_rvalid); // R2
  AST_R_READ_VALID: assert property (@(posedge clk_r) disable iff (!rst_n) (r_op == OP_READ) |=> r_rvalid); // R2
  AST_L_WRITE_DARK: assert property (@(posedge clk_l) disable iff (!rst_n) (l_op == OP_WRITE) |=> !l_q_drv); // R3
  AST_R_WRITE_DARK: assert property (@(posedge clk_r) disable iff (!rst_n) (r_op == OP_WRITE) |=> !r_q_drv); // R3
  AST_L_HOLD_KEEP: assert property (@(posedge clk_l) disable iff (!rst_n) l_hold |=> ($stable(l_addr_q) && $stable(l_op))); // R4
  AST_R_HOLD_KEEP: assert property (@(posedge clk_r) disable iff (!rst_n) r_hold |=> ($stable(r_addr_q) && $stable(r_op))); // R4
  AST_L_DESEL_DARK: assert property (@(posedge clk_l) disable iff (!rst_n) (l_op == OP_IDLE) |=> !l_q_drv); // R5
  AST_R_DESEL_DARK: assert property (@(posedge clk_r) disable iff (!rst_n) (r_op == OP_IDLE) |=> !r_q_drv); // R5
  AST_L_OE_DARK: assert property (@(posedge clk_l) disable iff (!rst_n) l_oe_n |-> !l_q_drv); // R6
  AST_R_OE_DARK: assert property (@(posedge clk_r) disable iff (!rst_n) r_oe_n |-> !r_q_drv); // R6
  AST_L_QUIET_ZERO: assert property (@(posedge clk_l) disable iff (!rst_n) !l_q_drv |-> (l_q == '0)); // R7
  AST_R_QUIET_ZERO: assert property (@(posedge clk_r) disable iff (!rst_n) !r_q_drv |-> (r_q == '0)); // R7

endmodule

bind dpram_sync2p dpram_sync2p_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_l    (clk_l),
  .clk_r    (clk_r),
  .rst_n    (rst_n),
  .l_hold   (l_hold),
  .l_oe_n   (l_oe_n),
  .l_q_drv  (l_q_drv),
  .l_q      (l_q),
  .l_op     (op_q[0]),
  .l_addr_q (addr_q[0]),
  .l_rvalid (rvalid_s[0]),
  .r_hold   (r_hold),
  .r_oe_n   (r_oe_n),
  .r_q_drv  (r_q_drv),
  .r_q      (r_q),
  .r_op     (op_q[1]),
  .r_addr_q (addr_q[1]),
  .r_rvalid (rvalid_s[1])
);

// File: tb/dpram_sync2p_bench.sv
module dpram_sync2p_bench;
  localparam int AW = 12;
  localparam int DW = 9;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic frz [2];
  logic seln [2];
  logic rdwn [2];
  logic oen [2];
  logic [AW-1:0] ad [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] q_l, q_r;
  logic drv_l, drv_r;

  int checks = 0;
  int failures = 0;
  string cur = "R11";

  always #10 clk = ~clk;

  dpram_sync2p u_dpram_sync2p (
    .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
    .l_hold(frz[0]), .l_sel_n(seln[0]), .l_rd_wn(rdwn[0]), .l_addr(ad[0]),
    .l_wdata(wd[0]), .l_oe_n(oen[0]), .l_q(q_l), .l_q_drv(drv_l),
    .r_hold(frz[1]), .r_sel_n(seln[1]), .r_rd_wn(rdwn[1]), .r_addr(ad[1]),
    .r_wdata(wd[1]), .r_oe_n(oen[1]), .r_q(q_r), .r_q_drv(drv_r)
  );

  // Reference model of the port pipelines and the word array.
  logic [DW-1:0] mm [NW];
  logic          m_sel [2];
  logic          m_wr  [2];
  logic [AW-1:0] m_ad  [2];
  logic [DW-1:0] m_d   [2];
  logic          m_rv  [2];
  logic [DW-1:0] m_rd  [2];

  function automatic logic [DW-1:0] fill_val(input int i);
    return DW'((i * 37 + 3) % 512);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic lw, rw;
    for (int p = 0; p < 2; p++) begin
      if (m_sel[p] && !m_wr[p]) begin
        m_rv[p] = 1'b1;
        m_rd[p] = mm[m_ad[p]];
      end else begin
        m_rv[p] = 1'b0;
      end
    end
    lw = m_sel[0] && m_wr[0];
    rw = m_sel[1] && m_wr[1];
    if (lw && !(rw && m_ad[0] == m_ad[1])) mm[m_ad[0]] = m_d[0];
    if (rw) mm[m_ad[1]] = m_d[1];
    for (int p = 0; p < 2; p++) begin
      if (!frz[p]) begin
        m_sel[p] = !seln[p];
        m_wr[p]  = !rdwn[p];
        m_ad[p]  = ad[p];
        m_d[p]   = wd[p];
      end
    end
  endtask

  task automatic compare();
    logic ed;
    logic [DW-1:0] eq;
    for (int p = 0; p < 2; p++) begin
      ed = m_rv[p] && !oen[p];
      eq = ed ? m_rd[p] : '0;
      chk(cur, p == 0 ? "left drv" : "right drv", {31'd0, p == 0 ? drv_l : drv_r}, {31'd0, ed});
      chk(cur, p == 0 ? "left q" : "right q", {23'd0, p == 0 ? q_l : q_r}, {23'd0, eq});
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #5;
    model_edge();
    compare();
  endtask

  // op: 0 deselect, 1 read, 2 write
  task automatic set(input int p, input int op, input int a, input int d);
    seln[p] = (op == 0);
    rdwn[p] = (op != 2);
    ad[p]   = AW'(a);
    wd[p]   = DW'(d);
  endtask

  task automatic expect_q(input int p, input logic [DW-1:0] v, input string tag);
    chk(tag, "drive flag", {31'd0, p == 0 ? drv_l : drv_r}, 32'd1);
    chk(tag, "read word", {23'd0, p == 0 ? q_l : q_r}, {23'd0, v});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int seed;
    int r;
    seed = 7;
    r = $urandom(seed);
    rst_n = 1'b0;
    for (int p = 0; p < 2; p++) begin
      frz[p] = 0; oen[p] = 0; set(p, 1, 0, 0);
      m_sel[p] = 0; m_wr[p] = 0; m_ad[p] = '0; m_d[p] = '0; m_rv[p] = 0; m_rd[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state is dark on both ports
    chk("R10", "left drv in reset", {31'd0, drv_l}, 32'd0);
    chk("R10", "right drv in reset", {31'd0, drv_r}, 32'd0);
    rst_n = 1'b1;
    cur = "R10";
    cyc();  // reads captured here are not yet on the pins

    cur = "R1";
    for (int i = 0; i < 16; i++) begin
      set(0, 2, i, fill_val(i)); set(1, 0, 0, 0);
      cyc();
    end
    set(0, 0, 0, 0);
    cyc();
    set(1, 2, NW - 1, 9'h1FF);
    cyc();
    set(1, 0, 0, 0); set(0, 1, NW - 1, 0);
    cyc();
    set(0, 0, 0, 0);
    cyc();
    expect_q(0, 9'h1FF, "R1");

    // R3: same-port write then immediate read-back
    cur = "R3";
    set(0, 2, 12, 9'h0F0); cyc();
    set(0, 1, 12, 0); cyc();
    set(0, 0, 0, 0); cyc();
    expect_q(0, 9'h0F0, "R3");

    // R8: cross-port ordering, left writes, right reads
    cur = "R8";
    set(0, 2, 5, 9'h123); set(1, 1, 5, 0); cyc();
    set(0, 0, 0, 0); cyc();
    expect_q(1, fill_val(5), "R8");
    set(1, 0, 0, 0); cyc();
    expect_q(1, 9'h123, "R8");

    // R9: both write one word on the same edge
    cur = "R9";
    set(0, 2, 7, 9'h0AA); set(1, 2, 7, 9'h155); cyc();
    set(0, 0, 0, 0); set(1, 0, 0, 0); cyc();
    set(0, 1, 7, 0); cyc();
    set(0, 0, 0, 0); cyc();
    expect_q(0, 9'h155, "R9");

    // R4: hold keeps a captured write, ignores new inputs
    cur = "R4";
    set(0, 2, 9, 9'h011); cyc();
    frz[0] = 1; set(0, 2, 9, 9'h1EE); cyc(); cyc();
    frz[0] = 0; set(0, 1, 9, 0); cyc();
    set(0, 0, 0, 0); cyc();
    expect_q(0, 9'h011, "R4");
    set(0, 1, 9, 0); cyc();
    frz[0] = 1; set(0, 1, 10, 0); cyc();
    expect_q(0, 9'h011, "R4");
    cyc();
    expect_q(0, 9'h011, "R4");

    // R6/R7: output enable without a clock edge
    oen[0] = 1; #1;
    chk("R6", "drv with oe high", {31'd0, drv_l}, 32'd0);
    chk("R7", "q with drv low", {23'd0, q_l}, 32'd0);
    oen[0] = 0; #1;
    expect_q(0, 9'h011, "R6");
    frz[0] = 0;

    // R5: deselected write has no effect and leaves the port dark
    cur = "R5";
    seln[0] = 1; rdwn[0] = 0; ad[0] = 9; wd[0] = '0; cyc();
    cyc();
    chk("R5", "drv after deselect", {31'd0, drv_l}, 32'd0);
    set(0, 1, 9, 0); cyc();
    set(0, 0, 0, 0); cyc();
    expect_q(0, 9'h011, "R5");

    // R2: read latency pattern, right port back-to-back reads
    cur = "R2";
    set(1, 1, 3, 0); cyc();
    set(1, 1, 4, 0); cyc();
    expect_q(1, fill_val(3), "R2");
    set(1, 0, 0, 0); cyc();
    expect_q(1, fill_val(4), "R2");

    // R11: random mix on both ports
    cur = "R11";
    for (int n = 0; n < 800; n++) begin
      for (int p = 0; p < 2; p++) begin
        int op;
        op = int'($urandom % 8);
        frz[p] = (op == 6);
        oen[p] = (($urandom % 6) == 0);
        if (op <= 2 || op == 7) set(p, 1, int'($urandom % 16), 0);
        else if (op <= 4) set(p, 2, int'($urandom % 16), int'($urandom % 512));
        else if (op == 5) set(p, 0, int'($urandom % 16), int'($urandom % 512));
        else begin
          ad[p] = AW'($urandom % 16); wd[p] = DW'($urandom % 512);
        end
      end
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule